// File: doc/BRIEF.md
# Coin-Operated Drink Vending Controller

This block is the sequencing logic of a drink dispenser that sells one item priced at 35 cents. A buyer picks a coin type on a two-bit selector and then presses a register button. Each new press of the button adds the selected coin to the running credit.

The credit is held in units of nickels. There are seven accumulating positions, 0 to 30 cents. As soon as the credit reaches the price or goes past it, the controller moves into a dispensing position, one for each possible change amount (0 to 20 cents). The drink output stays high while the controller is in a dispensing position. The change owed is presented as a nickel count for one cycle, together with a strobe.

The controller has no idle return path. It stays in the dispensing position until the next registered coin, and that coin opens a new purchase as its first credit.

Top module: `soda_vend_fsm`

## Requirements
- R1: A synchronous reset, asserted at any time, leaves credit_nickels at 0 and soda_out, change_strobe and change_nickels low after the clock edge.
- R2: A registered coin adds to the credit according to coin_sel: 2'b01 adds one nickel (5 cents), 2'b10 adds two nickels (10 cents) and 2'b11 adds five nickels (25 cents). The new credit appears on credit_nickels after the clock edge at which the press is first seen high.
- R3: A press made while coin_sel is 2'b00 changes no output.
- R4: A coin is registered only on a low-to-high change of press. Holding press high registers exactly one coin, even if coin_sel changes while the button is held.
- R5: While the total is below 7 nickels, soda_out stays low and credit_nickels shows the total, which is always at most 6.
- R6: When the total reaches 7 nickels or more, soda_out rises and credit_nickels reads 0. soda_out stays high until the next registered coin.
- R7: On entry to dispensing, change_strobe is high for exactly one cycle and change_nickels carries the total minus 7 (a value from 0 to 4). Outside that cycle change_nickels is 0.
- R8: A coin registered while dispensing drops soda_out and starts a new credit equal to that coin's value alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coin_sel | input | 2 | Coin type: 00 none, 01 nickel, 10 dime, 11 quarter |
| press | input | 1 | Register button; a rising change counts one coin |
| soda_out | output | 1 | High while a drink is being dispensed |
| change_strobe | output | 1 | One-cycle pulse on entry to dispensing |
| change_nickels | output | 3 | Change owed, in nickels, during the strobe cycle |
| credit_nickels | output | 4 | Current credit, in nickels |

## Verification
The assertions check on every cycle that the credit never reaches the price while the controller is accumulating, and that the change strobe is a lone pulse that comes with soda_out. They also check that change_nickels is zero away from the strobe, that dispensing holds while no coin arrives, that a coin during dispensing restarts the credit, and that the press edge detector never fires twice in a row.

The right credit for each coin code, the exact change for each path to the price, a 00 press having no effect, and reset in the middle of a purchase can only be shown by the bench. It checks these with directed sequences and with random coin and hold patterns, compared against its own model.

// File: rtl/soda_pkg.sv
package soda_pkg;
    typedef enum logic {
        MODE_ACC = 1'b0,
        MODE_DSP = 1'b1
    } vend_mode_e;
endpackage

// File: rtl/press_edge.sv
module press_edge (
    input  logic clk,
    input  logic rst,
    input  logic press,
    output logic fire
);
    logic seen_d, seen_q;

    always_comb begin
        seen_d = press;
    end

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= seen_d;
    end

    assign fire = press & ~seen_q;

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);
endmodule

// File: rtl/coin_value.sv
module coin_value #(
    parameter int NICKEL_VAL  = 1,
    parameter int DIME_VAL    = 2,
    parameter int QUARTER_VAL = 5,
    parameter int W           = 4
) (
    input  logic [1:0]   sel,
    output logic [W-1:0] worth
);
    always_comb begin
        case (sel)
            2'b01:   worth = W'(NICKEL_VAL);
            2'b10:   worth = W'(DIME_VAL);
            2'b11:   worth = W'(QUARTER_VAL);
            default: worth = '0;
        endcase
    end
endmodule

// File: rtl/soda_vend_fsm.sv
module soda_vend_fsm
    import soda_pkg::*;
#(
    parameter int PRICE       = 7,
    parameter int NICKEL_VAL  = 1,
    parameter int DIME_VAL    = 2,
    parameter int QUARTER_VAL = 5,
    localparam int SUM_W      = $clog2(PRICE + QUARTER_VAL),
    localparam int CHG_W      = $clog2(QUARTER_VAL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       coin_sel,
    input  logic             press,
    output logic             soda_out,
    output logic             change_strobe,
    output logic [CHG_W-1:0] change_nickels,
    output logic [SUM_W-1:0] credit_nickels
);
    typedef struct packed {
        vend_mode_e       mode;
        logic [SUM_W-1:0] amt;
        logic [CHG_W-1:0] chg;
        logic             strobe;
    } vend_state_t;

    vend_state_t st_d, st_q;
    logic             fire;
    logic [SUM_W-1:0] worth;
    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] total;

    press_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .press (press),
        .fire  (fire)
    );

    coin_value #(
        .NICKEL_VAL  (NICKEL_VAL),
        .DIME_VAL    (DIME_VAL),
        .QUARTER_VAL (QUARTER_VAL),
        .W           (SUM_W)
    ) u_value (
        .sel   (coin_sel),
        .worth (worth)
    );

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        st_d.chg    = '0;
        base        = (st_q.mode == MODE_ACC) ? st_q.amt : '0;
        total       = base + worth;
        if (fire && worth != '0) begin
            if (total >= SUM_W'(PRICE)) begin
                st_d.mode   = MODE_DSP;
                st_d.amt    = '0;
                st_d.chg    = CHG_W'(total - SUM_W'(PRICE));
                st_d.strobe = 1'b1;
            end else begin
                st_d.mode = MODE_ACC;
                st_d.amt  = total;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{mode: MODE_ACC, amt: '0, chg: '0, strobe: 1'b0};
        else     st_q <= st_d;
    end

    assign soda_out       = (st_q.mode == MODE_DSP);
    assign credit_nickels = st_q.amt;
    assign change_nickels = st_q.chg;
    assign change_strobe  = st_q.strobe;

    // R5
    credit_below_price_chk: assert property (@(posedge clk) disable iff (rst)
        !soda_out |-> credit_nickels < SUM_W'(PRICE));

    // R7
    change_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        change_strobe |=> !change_strobe);

    // R7
    change_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (change_nickels != '0) |-> change_strobe);

    // R6
    strobe_with_soda_chk: assert property (@(posedge clk) disable iff (rst)
        change_strobe |-> soda_out);

    // R6
    dispense_holds_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(soda_out) && !$past(fire) && !$past(rst)) |-> soda_out);

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && coin_sel != 2'b00 && soda_out) |=> (!soda_out && credit_nickels != '0));
endmodule

// File: tb/sim_soda_vend_fsm.sv
`timescale 1ns/1ps
module sim_soda_vend_fsm;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] coin_sel;
    logic       press;
    logic       soda_out;
    logic       change_strobe;
    logic [2:0] change_nickels;
    logic [3:0] credit_nickels;

    int n_cmp = 0;
    int n_bad = 0;
    int m_cred = 0;
    bit m_disp = 1'b0;

    always #2.5 clk = ~clk;

    soda_vend_fsm u0 (
        .clk            (clk),
        .rst            (rst),
        .coin_sel       (coin_sel),
        .press          (press),
        .soda_out       (soda_out),
        .change_strobe  (change_strobe),
        .change_nickels (change_nickels),
        .credit_nickels (credit_nickels)
    );

    function automatic int coin_worth(input logic [1:0] c);
        case (c)
            2'b01:   return 1;
            2'b10:   return 2;
            2'b11:   return 5;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_idle_outputs(input string req);
        check({req, " credit"}, credit_nickels, m_cred);
        check({req, " soda"},   soda_out, m_disp);
        check({req, " strobe"}, change_strobe, 0);
        check({req, " change"}, change_nickels, 0);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        press = 1'b0;
        coin_sel = 2'b00;
        @(negedge clk);
        m_cred = 0;
        m_disp = 1'b0;
        check_idle_outputs("R1 reset");
        rst = 1'b0;
    endtask

    // Register one coin, keep the button held for extra cycles, then release.
    task automatic reg_coin(input logic [1:0] code, input int hold);
        int w, base, tot, exp_chg, exp_str;
        @(negedge clk);
        coin_sel = code;
        press = 1'b1;
        w = coin_worth(code);
        exp_chg = 0;
        exp_str = 0;
        if (w != 0) begin
            base = m_disp ? 0 : m_cred;
            tot = base + w;
            if (tot >= 7) begin
                m_disp = 1'b1;
                m_cred = 0;
                exp_chg = tot - 7;
                exp_str = 1;
            end else begin
                m_disp = 1'b0;
                m_cred = tot;
            end
        end
        @(negedge clk);
        if (w == 0) begin
            check_idle_outputs("R3 null press");
        end else begin
            check("R2 credit", credit_nickels, m_cred);
            check("R6 soda", soda_out, m_disp);
            check("R7 strobe", change_strobe, exp_str);
            check("R7 change", change_nickels, exp_chg);
        end
        for (int i = 1; i < hold; i++) begin
            coin_sel = 2'($urandom_range(3));
            @(negedge clk);
            check_idle_outputs("R4 held");
        end
        press = 1'b0;
        coin_sel = 2'($urandom_range(3));
        @(negedge clk);
        check_idle_outputs("R7 after pulse");
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1;
        press = 1'b0;
        coin_sel = 2'b00;
        repeat (2) @(negedge clk);
        check_idle_outputs("R1 power-up");
        rst = 1'b0;

        // R2 R5 R6: seven nickels give exact price, no change
        for (int i = 0; i < 7; i++) reg_coin(2'b01, 1);
        // R8: a quarter while dispensing starts a new purchase at 5
        reg_coin(2'b11, 1);
        // R7: quarter on 25 gives 10 nickels -> change 3
        reg_coin(2'b11, 1);
        // R2: dimes 2,4,6 then 8 -> change 1
        for (int i = 0; i < 4; i++) reg_coin(2'b10, 2);
        // R7: 30 cents then a quarter -> change 4
        reg_coin(2'b01, 1);
        for (int i = 0; i < 6; i++) reg_coin(2'b01, 1);
        reg_coin(2'b01, 1);
        for (int i = 0; i < 5; i++) reg_coin(2'b01, 1);
        reg_coin(2'b11, 1);
        // R3: null presses at a mid credit
        reg_coin(2'b10, 1);
        reg_coin(2'b00, 1);
        reg_coin(2'b00, 3);
        // R4: long hold with changing selector
        reg_coin(2'b01, 6);
        // R1: reset in the middle of a purchase and while dispensing
        do_reset();
        reg_coin(2'b11, 1);
        reg_coin(2'b11, 1);
        do_reset();

        // Random mix
        for (int k = 0; k < 400; k++) begin
            reg_coin(2'($urandom_range(3)), int'($urandom_range(1, 3)));
            if ($urandom_range(49) == 0) do_reset();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule